// File: doc/BRIEF.md
# Reloadable down-counting interval timer

This block is one timer channel on a simple word-addressed register bus. Software sets a start value and a control word. The channel then counts down by one on each pulse of the tick input it has selected. When a tick arrives while the count is zero, the count underflows. In periodic mode the counter then takes the start value again. In free-running mode it continues from all ones. Every underflow raises a level interrupt, and the interrupt stays high until software writes anything to the clear address.

Two single-cycle tick-enable inputs, one fast and one slow, come from clock generation outside the block. A control bit chooses which of them drives the counter. The counter width is a parameter and is normally 16 or 32 bits. To arm a new interval, software disables the channel, writes the start value and enables the channel again. A start-value write made while the channel is running also takes effect at once.

Top module: `interval_timer`

## Requirements
- R1: After reset, the start value, the count, the control word and the interrupt are all zero.
- R2: An access hits a register only when the address bits [1:0] are zero. Address bits [3:2] select the register: 0 is the start value, 1 is the current count, 2 is control and 3 is clear. Control keeps only bit 7 (run), bit 6 (periodic) and bit 3 (fast tick select). A control read returns those three bits in place and zero elsewhere.
- R3: A control write that sets the run bit while the channel is stopped copies the start value into the counter on the next clock.
- R4: While running, the count drops by one on each pulse of the selected tick. With bit 3 set the selected tick is the fast input, and with bit 3 clear it is the slow input. Pulses on the other input do nothing.
- R5: While the run bit is clear, the count holds its value whatever the ticks do.
- R6: In periodic mode, an underflow reloads the counter from the start value.
- R7: With periodic mode off, an underflow sets the counter to all ones (0xFFFF at the default width), and counting continues from there.
- R8: Every underflow sets the interrupt output, and it stays set.
- R9: A write of any data to the clear register drops the interrupt on the next clock. A read of the clear register returns zero.
- R10: If a clear write and an underflow happen in the same cycle, the interrupt stays set.
- R11: A start-value write while running sets the counter to the written value on the next clock, and that cycle has no underflow. A start-value write while stopped changes only the start value register.
- R12: Writes to the count register have no effect.
- R13: The start value and the count hold the low CNT_W bits of the bus. When they are read, the bits above CNT_W are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address within the channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| tick_fast | input | 1 | Fast tick enable pulse |
| tick_slow | input | 1 | Slow tick enable pulse |
| irq | output | 1 | Level interrupt, set on underflow |

## Verification
The bench goes after the zero boundary. A design that decrements once too often or too early would show the wrap or the reload one tick off, and a design that takes the wrong value on underflow would show it at once. It drives a clear write and an underflow into the same cycle: a design that lets the clear win loses an interrupt. It writes the start value while the channel runs and while it is stopped, and it writes the count register directly. These catch a counter that ignores live reloads, or one that can be corrupted through the read-only register. A long stretch of random ticks and accesses, checked against a behavioural model, exposes tick-source mix-ups and control bits decoded in the wrong place.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int unsigned BUS_W = 32;

    // Word index taken from address bits [3:2]
    typedef enum logic [1:0] {
        REG_START = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLEAR = 2'd3
    } reg_sel_e;

    // Control word bit positions (software-visible layout)
    localparam int unsigned RUN_BIT  = 7;
    localparam int unsigned PER_BIT  = 6;
    localparam int unsigned FAST_BIT = 3;

    typedef struct packed {
        logic run;
        logic per;
        logic fast;
    } ctrl_t;

endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [BUS_W-1:0] bus_rdata,
    output logic [CNT_W-1:0] start_val,
    output ctrl_t            ctrl,
    output logic             ld_wr,
    output logic             clr_wr,
    output logic             arm
);

    typedef struct packed {
        logic [CNT_W-1:0] start;
        ctrl_t            ctrl;
    } regs_t;

    regs_t            regs_d, regs_q;
    reg_sel_e         sel;
    logic             hit;
    logic             wr_en;
    logic             ct_wr;
    logic [BUS_W-1:0] start_ext;
    logic [BUS_W-1:0] cnt_ext;
    logic [BUS_W-1:0] ctrl_rd;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Zero-extend counter-width values onto the bus
    generate
        if (CNT_W < BUS_W) begin : g_ext
            assign start_ext = {{(BUS_W-CNT_W){1'b0}}, regs_q.start};
            assign cnt_ext   = {{(BUS_W-CNT_W){1'b0}}, cnt_val};
        end else begin : g_full
            assign start_ext = regs_q.start;
            assign cnt_ext   = cnt_val;
        end
    endgenerate

    always_comb begin
        sel    = reg_sel_e'(bus_addr[3:2]);
        hit    = bus_sel && (bus_addr[1:0] == 2'b00);
        wr_en  = hit && bus_wr;
        ld_wr  = wr_en && (sel == REG_START);
        ct_wr  = wr_en && (sel == REG_CTRL);
        clr_wr = wr_en && (sel == REG_CLEAR);
        arm    = ct_wr && bus_wdata[RUN_BIT] && !regs_q.ctrl.run;

        regs_d = regs_q;
        if (ld_wr) begin
            regs_d.start = bus_wdata[CNT_W-1:0];
        end
        if (ct_wr) begin
            regs_d.ctrl.run  = bus_wdata[RUN_BIT];
            regs_d.ctrl.per  = bus_wdata[PER_BIT];
            regs_d.ctrl.fast = bus_wdata[FAST_BIT];
        end

        ctrl_rd           = '0;
        ctrl_rd[RUN_BIT]  = regs_q.ctrl.run;
        ctrl_rd[PER_BIT]  = regs_q.ctrl.per;
        ctrl_rd[FAST_BIT] = regs_q.ctrl.fast;

        bus_rdata = '0;
        if (hit && !bus_wr) begin
            case (sel)
                REG_START: bus_rdata = start_ext;
                REG_COUNT: bus_rdata = cnt_ext;
                REG_CTRL:  bus_rdata = ctrl_rd;
                default:   bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign start_val = regs_q.start;
    assign ctrl      = regs_q.ctrl;

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
    import itmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] start_val,
    input  logic             ld_wr,
    input  logic [CNT_W-1:0] ld_data,
    input  logic             arm,
    input  logic             tick_fast,
    input  logic             tick_slow,
    output logic [CNT_W-1:0] cnt_val,
    output logic             underflow
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic tick;

    always_comb begin
        tick      = ctrl.fast ? tick_fast : tick_slow;
        cnt_d     = cnt_q;
        underflow = 1'b0;
        if (ld_wr && ctrl.run) begin
            cnt_d.cnt = ld_data;
        end else if (arm) begin
            cnt_d.cnt = start_val;
        end else if (ctrl.run && tick) begin
            if (cnt_q.cnt == '0) begin
                underflow = 1'b1;
                cnt_d.cnt = ctrl.per ? start_val : '1;
            end else begin
                cnt_d.cnt = cnt_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_val = cnt_q.cnt;

endmodule

// File: rtl/itmr_irq.sv
module itmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic irq
);

    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t irq_d, irq_q;

    // Set has priority over clear
    always_comb begin
        irq_d = irq_q;
        if (set_ev) begin
            irq_d.pend = 1'b1;
        end else if (clr_ev) begin
            irq_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq = irq_q.pend;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itmr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        tick_fast,
    input  logic        tick_slow,
    output logic        irq
);

    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] start_val;
    ctrl_t            ctrl;
    logic             ld_wr;
    logic             clr_wr;
    logic             arm;
    logic             underflow;

    itmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_val),
        .bus_rdata (bus_rdata),
        .start_val (start_val),
        .ctrl      (ctrl),
        .ld_wr     (ld_wr),
        .clr_wr    (clr_wr),
        .arm       (arm)
    );

    itmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .start_val (start_val),
        .ld_wr     (ld_wr),
        .ld_data   (bus_wdata[CNT_W-1:0]),
        .arm       (arm),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .cnt_val   (cnt_val),
        .underflow (underflow)
    );

    itmr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (underflow),
        .clr_ev (clr_wr),
        .irq    (irq)
    );

endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_run,
    input logic             ctl_per,
    input logic             arm,
    input logic             ld_wr,
    input logic             clr_wr,
    input logic             underflow,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] start_val,
    input logic             irq,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_rdata
);

    assert_arm_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> cnt_val == $past(start_val));

    assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_run && !arm) |=> cnt_val == $past(cnt_val));

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && ctl_per) |=> cnt_val == $past(start_val));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !ctl_per) |=> (&cnt_val));

    assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> irq);

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !underflow) |=> !irq);

    assert_clear_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 4'hC) |-> bus_rdata == 32'h0);

    assert_live_load_no_uf_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wr && ctl_run) |-> !underflow);

endmodule

bind interval_timer itmr_checker #(.CNT_W(CNT_W)) u_itmr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_run   (ctrl.run),
    .ctl_per   (ctrl.per),
    .arm       (arm),
    .ld_wr     (ld_wr),
    .clr_wr    (clr_wr),
    .underflow (underflow),
    .cnt_val   (cnt_val),
    .start_val (start_val),
    .irq       (irq),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;

    localparam logic [31:0] MASK = 32'h0000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        irq;

    always #2 clk = ~clk;

    interval_timer #(.CNT_W(16)) u_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .irq       (irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Behavioural reference model
    logic [31:0] m_start, m_cnt;
    bit          m_run, m_per, m_fast, m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_start = 0; m_cnt = 0; m_run = 0; m_per = 0; m_fast = 0; m_irq = 0;
        end else begin
            bit hitw, uf, tk;
            logic [31:0] nxt;
            hitw = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
            tk   = m_fast ? tick_fast : tick_slow;
            uf   = 0;
            nxt  = m_cnt;
            if (hitw && bus_addr[3:2] == 2'd0 && m_run)
                nxt = bus_wdata & MASK;
            else if (hitw && bus_addr[3:2] == 2'd2 && bus_wdata[7] && !m_run)
                nxt = m_start;
            else if (m_run && tk) begin
                if (m_cnt == 0) begin
                    uf  = 1;
                    nxt = m_per ? m_start : MASK;
                end else begin
                    nxt = m_cnt - 1;
                end
            end
            if (uf) m_irq = 1;
            else if (hitw && bus_addr[3:2] == 2'd3) m_irq = 0;
            if (hitw && bus_addr[3:2] == 2'd0) m_start = bus_wdata & MASK;
            if (hitw && bus_addr[3:2] == 2'd2) begin
                m_run = bus_wdata[7]; m_per = bus_wdata[6]; m_fast = bus_wdata[3];
            end
            m_cnt = nxt;
        end
    end

    function automatic logic [31:0] m_read(logic [3:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[3:2])
            2'd0: return m_start;
            2'd1: return m_cnt;
            2'd2: return {24'h0, m_run, m_per, 2'b00, m_fast, 3'b000};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // irq compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #1;
            chk("R8_R9_R10 irq vs model", {31'h0, irq}, {31'h0, m_irq});
        end
    end

    task automatic idle();
        bus_sel = 0; bus_wr = 0; tick_fast = 0; tick_slow = 0;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        @(negedge clk);
        idle();
    endtask

    task automatic ticks(bit f, bit s, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_fast = f; tick_slow = s;
            @(negedge clk);
            idle();
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(4'h0, 32'h0, "R1 start after reset");
        rd(4'h4, 32'h0, "R1 count after reset");
        rd(4'h8, 32'h0, "R1 ctrl after reset");
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);

        // R2 control keeps bits 7,6,3 only; misaligned access misses
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h8, 32'h0000_00C8, "R2 ctrl readback");
        rd(4'h9, 32'h0, "R2 misaligned read");
        wr(4'h8, 32'h0);
        wr(4'h1, 32'h0000_0055);
        rd(4'h0, 32'h0, "R2 misaligned write ignored");

        // R3 arm, R4 fast ticks, slow ignored
        wr(4'h0, 32'h5);
        wr(4'h8, 32'h88);
        rd(4'h4, 32'h5, "R3 arm copies start");
        ticks(1, 0, 3);
        rd(4'h4, 32'h2, "R4 fast decrements");
        ticks(0, 1, 4);
        rd(4'h4, 32'h2, "R4 slow ignored when fast selected");

        // R5 stopped holds
        wr(4'h8, 32'h08);
        ticks(1, 1, 3);
        rd(4'h4, 32'h2, "R5 hold while stopped");

        // R7 wrap, R8 irq
        wr(4'h8, 32'h88);
        rd(4'h4, 32'h5, "R3 re-arm");
        ticks(1, 0, 5);
        rd(4'h4, 32'h0, "R4 reached zero");
        chk("R8 no irq before underflow", {31'h0, irq}, 32'h0);
        ticks(1, 0, 1);
        rd(4'h4, 32'h0000_FFFF, "R7 wrap to all ones");
        chk("R8 irq set", {31'h0, irq}, 32'h1);
        ticks(1, 0, 1);
        rd(4'h4, 32'h0000_FFFE, "R7 continues after wrap");
        chk("R8 irq stays", {31'h0, irq}, 32'h1);

        // R9 clear
        wr(4'hC, 32'h0);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);
        rd(4'hC, 32'h0, "R9 clear reads zero");

        // R6 periodic reload, R10 simultaneous clear
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h2);
        wr(4'h8, 32'hC8);
        ticks(1, 0, 2);
        rd(4'h4, 32'h0, "R6 at zero");
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 4'hC; bus_wdata = 32'h1234; tick_fast = 1;
        @(negedge clk);
        idle();
        #1;
        chk("R10 irq survives clear", {31'h0, irq}, 32'h1);
        rd(4'h4, 32'h2, "R6 periodic reload");
        wr(4'hC, 32'hDEAD_BEEF);
        chk("R9 clear any data", {31'h0, irq}, 32'h0);

        // R11 live start write and stopped start write
        wr(4'h0, 32'h64);
        rd(4'h4, 32'h64, "R11 live write sets counter");
        wr(4'h8, 32'h48);
        wr(4'h0, 32'h7);
        rd(4'h4, 32'h64, "R11 stopped write leaves counter");
        wr(4'h8, 32'hC8);
        rd(4'h4, 32'h7, "R11 new start used on arm");

        // R12 count ignores writes
        wr(4'h4, 32'h1234);
        rd(4'h4, 32'h7, "R12 count write ignored");

        // R13 width
        wr(4'h0, 32'hABCD_FFFF);
        rd(4'h0, 32'h0000_FFFF, "R13 start truncated");
        rd(4'h4, 32'h0000_FFFF, "R13 count upper zero");

        // R4 slow tick selection
        wr(4'h8, 32'h00);
        wr(4'h0, 32'h10);
        wr(4'h8, 32'h80);
        ticks(0, 1, 3);
        ticks(1, 0, 3);
        rd(4'h4, 32'hD, "R4 slow selected");

        // Random phase compared with the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            @(negedge clk);
            r = $urandom_range(0, 15);
            tick_fast = $urandom_range(0, 1);
            tick_slow = $urandom_range(0, 1);
            bus_sel = 1;
            bus_addr = 4'($urandom_range(0, 3) * 4);
            if (r == 0) begin
                bus_wr = 1;
                bus_wdata = (bus_addr == 4'h0) ? 32'($urandom_range(0, 40)) : $urandom;
            end else begin
                bus_wr = 0;
                #1;
                chk("R4_R6_R7_R11 random read vs model", bus_rdata, m_read(bus_addr));
            end
        end
        @(negedge clk);
        idle();
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule